// File: doc/BRIEF.md
# Power-Up and Master-Reset Sequencer

This block sequences the start-up of a device. When the power-good input rises, or when the active-low master reset pin falls at any later time, it runs an internal initialisation of fixed length. During that initialisation it asserts a strobe that tells every register to load its initial value. The output drivers stay disabled, in high impedance, until initialisation has finished and the reset pin is high again. If both conditions hold, the output-enable permission is raised. Otherwise it stays low, and a busy flag reports this.

The reset pin is asynchronous. It passes through a two-stage synchroniser, and edge detection works on the synchronised levels. A low pulse on the pin that lasts fewer than a set number of clock cycles is reported on a one-cycle violation flag. Power-good low acts as the asynchronous reset of the whole block. Both the initialisation length (`INIT_CYC`) and the minimum pulse width (`MIN_LOW`) are counted in clock cycles.

Top module: `por_seq`

## Requirements
- R1: While `pwr_good_i` is low, `out_en_o` is 0, `busy_o` is 1, `init_o` is 1 and `width_err_o` is 0, whatever the reset pin does.
- R2: With `mrst_n_i` held high, `init_o` stays high for exactly `INIT_CYC` clock edges after `pwr_good_i` rises, and `out_en_o` is 1 from edge `INIT_CYC` on.
- R3: If `mrst_n_i` is low when power-good rises and returns high H cycles later, `init_o` stays high up to and including edge `INIT_CYC+1`, and `out_en_o` rises at edge `2+max(INIT_CYC,H)`.
- R4: If `mrst_n_i` falls just before edge j+1, `out_en_o` drops after edge j+2, and `init_o` is high from edge j+2 through edge j+INIT_CYC+1.
- R5: A falling reset pin restarts the initialisation at any time, including while a previous initialisation is still counting.
- R6: `out_en_o` is 1 only when the count has finished and the synchronised reset pin is high. After a low pulse of L cycles that starts before edge j+1, it rises at edge j+2+max(INIT_CYC,L).
- R7: After a low pulse of L cycles that starts before edge j+1, `width_err_o` is high for the single cycle after edge j+L+2 if L < `MIN_LOW`. It stays low for any pulse with L >= `MIN_LOW`.
- R8: `busy_o` is always the inverse of `out_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_good_i | input | 1 | Power good; low resets the block asynchronously |
| mrst_n_i | input | 1 | Asynchronous active-low master reset pin |
| out_en_o | output | 1 | Output drivers may be enabled |
| init_o | output | 1 | Register-initialise strobe, high while initialising |
| busy_o | output | 1 | High while outputs are held disabled |
| width_err_o | output | 1 | One-cycle flag for a reset pulse shorter than `MIN_LOW` |

## Verification
The case hardest to reach is a reset edge that lands inside an initialisation already under way. To reach it, the bench powers up with the pin high and starts a low pulse at every offset from the first cycle to a few cycles past the end of the count, so some restarts truncate the power-up count and others follow it. At each offset, pulse lengths are swept on both sides of the minimum width. The bench then computes the release edge and the violation edge arithmetically from the offset and the length. A separate sweep holds the pin low across power-up for a range of durations.

// File: rtl/por_pkg.sv
package por_pkg;

    // Events derived from the synchronised master reset pin
    typedef struct packed {
        logic lvl;   // synchronised pin level
        logic fall;  // pin is about to go low at the next edge
        logic rise;  // pin is about to go high at the next edge
    } mr_ev_t;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_st_t;

endpackage

// File: rtl/por_sync.sv
module por_sync
    import por_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   pin_i,
    output mr_ev_t ev_o
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        ev_o.lvl  = st_q.s2;
        ev_o.fall = st_q.s2 & ~st_q.s1;
        ev_o.rise = ~st_q.s2 & st_q.s1;
    end

    // Reset to high so a pin tied high produces no edge after power-up
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{s1: 1'b1, s2: 1'b1};
        else         st_q <= st_d;
    end

endmodule

// File: rtl/por_init_cnt.sv
module por_init_cnt #(
    parameter int INIT_CYC = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic running_o
);

    localparam int CW = $clog2(INIT_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)          cnt_d = CW'(INIT_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
        running_o = (cnt_q != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= CW'(INIT_CYC);
        else         cnt_q <= cnt_d;
    end

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && !restart_i) |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/por_width_chk.sv
module por_width_chk
    import por_pkg::*;
#(
    parameter int MIN_LOW = 4
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  mr_ev_t ev_i,
    output logic   err_o
);

    localparam int LW = $clog2(MIN_LOW + 1);

    logic [LW-1:0] low_d, low_q;
    logic          err_d, err_q;

    always_comb begin
        low_d = low_q;
        err_d = 1'b0;
        if (ev_i.fall) begin
            low_d = LW'(1);
        end else if (!ev_i.lvl && !ev_i.rise) begin
            if (low_q != LW'(MIN_LOW)) low_d = low_q + LW'(1);
        end else if (ev_i.rise) begin
            err_d = (low_q < LW'(MIN_LOW));
            low_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_q <= '0;
            err_q <= 1'b0;
        end else begin
            low_q <= low_d;
            err_q <= err_d;
        end
    end

    assign err_o = err_q;

    // R7
    low_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_q <= LW'(MIN_LOW));

    // R7
    err_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |-> $past(ev_i.rise));

endmodule

// File: rtl/por_seq.sv
module por_seq
    import por_pkg::*;
#(
    parameter int INIT_CYC = 64,
    parameter int MIN_LOW  = 4
) (
    input  logic clk_i,
    input  logic pwr_good_i,
    input  logic mrst_n_i,
    output logic out_en_o,
    output logic init_o,
    output logic busy_o,
    output logic width_err_o
);

    mr_ev_t mr_ev;
    logic   running;

    por_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (pwr_good_i),
        .pin_i  (mrst_n_i),
        .ev_o   (mr_ev)
    );

    por_init_cnt #(.INIT_CYC(INIT_CYC)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (pwr_good_i),
        .restart_i (mr_ev.fall),
        .running_o (running)
    );

    por_width_chk #(.MIN_LOW(MIN_LOW)) u_wchk (
        .clk_i  (clk_i),
        .rst_ni (pwr_good_i),
        .ev_i   (mr_ev),
        .err_o  (width_err_o)
    );

    always_comb begin
        out_en_o = !running && mr_ev.lvl;
        busy_o   = !out_en_o;
        init_o   = running;
    end

    // R4
    fall_restart_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        mr_ev.fall |=> (init_o && !out_en_o));

    // R6
    release_after_init_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $fell(busy_o) |-> !init_o);

endmodule

// File: tb/tb_por_seq.sv
module tb_por_seq;

    localparam int N  = 6;
    localparam int MW = 3;

    logic clk = 1'b0;
    logic pwr_good, mrst_n;
    logic out_en, init, busy, werr;

    int vectors = 0;
    int fails   = 0;

    por_seq #(.INIT_CYC(N), .MIN_LOW(MW)) dut (
        .clk_i       (clk),
        .pwr_good_i  (pwr_good),
        .mrst_n_i    (mrst_n),
        .out_en_o    (out_en),
        .init_o      (init),
        .busy_o      (busy),
        .width_err_o (werr)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string sig, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, sig, act, exp, $time);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Power cycle; pin level during reset given by low_at_reset
    task automatic power_cycle(input logic low_at_reset);
        @(negedge clk);
        pwr_good = 1'b0;
        mrst_n   = ~low_at_reset;
        #1;
        // R1
        chk("R1", "out_en", out_en, 1'b0);
        chk("R1", "busy", busy, 1'b1);
        chk("R1", "init", init, 1'b1);
        chk("R1", "width_err", werr, 1'b0);
        @(negedge clk);
        mrst_n = ~mrst_n;  // pin activity under reset has no effect
        @(negedge clk);
        #1;
        chk("R1", "out_en", out_en, 1'b0);
        chk("R1", "init", init, 1'b1);
        chk("R1", "width_err", werr, 1'b0);
        mrst_n   = ~low_at_reset;
        pwr_good = 1'b1;
    endtask

    // Pulse of length L starting before edge j+1; k is the edge count since release
    task automatic run_pulse(input int j, input int L, input string req);
        int last = j + imax(N, L) + 5;
        for (int k = 0; k <= last; k++) begin
            logic e_init, e_oe, e_err;
            if (k > 0) @(negedge clk);
            #1;
            e_init = (k < N) || (k >= j + 2 && k <= j + N + 1);
            e_oe   = (k >= N && k < j + 2) || (k >= j + 2 + imax(N, L));
            e_err  = (k == j + L + 2) && (L < MW);
            chk(req, "init", init, e_init);
            chk(req, "out_en", out_en, e_oe);
            chk("R8", "busy", busy, ~e_oe);
            chk("R7", "width_err", werr, e_err);
            if (k == j)     mrst_n = 1'b0;
            if (k == j + L) mrst_n = 1'b1;
        end
    endtask

    // Pin low across power-up, released H cycles after power-good rises
    task automatic run_held(input int H);
        int last = imax(N, H) + 6;
        for (int k = 0; k <= last; k++) begin
            logic e_oe;
            if (k > 0) @(negedge clk);
            #1;
            e_oe = (k >= 2 + imax(N, H));
            // R3
            chk("R3", "init", init, k <= N + 1);
            chk("R3", "out_en", out_en, e_oe);
            chk("R8", "busy", busy, ~e_oe);
            chk("R7", "width_err", werr, (k == H + 2) && (H < MW));
            if (k == H) mrst_n = 1'b1;
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        pwr_good = 1'b0;
        mrst_n   = 1'b1;

        // R2: pin tied high, plain power-up
        power_cycle(1'b0);
        for (int k = 0; k <= N + 4; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk("R2", "init", init, k < N);
            chk("R2", "out_en", out_en, k >= N);
            chk("R8", "busy", busy, k < N);
            chk("R2", "width_err", werr, 1'b0);
        end

        // R4 R5 R6 R7: pulse at every offset, lengths around the minimum
        for (int j = 0; j <= N + 3; j++) begin
            for (int L = 1; L <= MW + 3; L++) begin
                power_cycle(1'b0);
                run_pulse(j, L, (j + 2 < N) ? "R5" : ((L > N) ? "R6" : "R4"));
            end
        end

        // R3: held low across power-up
        for (int H = 1; H <= N + 4; H++) begin
            power_cycle(1'b1);
            run_held(H);
        end

        // R1: power-good dropping mid-operation disables at once
        @(negedge clk);
        pwr_good = 1'b0;
        #1;
        chk("R1", "out_en", out_en, 1'b0);
        chk("R1", "init", init, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule